// File: doc/BRIEF.md
# Auto-Increment Word Program Controller with Ready/Busy on SO

This block is the command layer behind a serial-flash front end. The front end deserializes whole bytes and passes them in while the chip-select input (active low) is held low. Here each byte is gathered into a frame buffer. When chip select rises, the frame is decoded and executed. The block keeps three flags: a write-enable latch, an auto-increment programming flag and a ready/busy reporting enable. On an accepted word-program command it starts a modeled internal program operation. The length of that operation is set by a down-counter.

Auto-increment programming writes one 16-bit word per frame. The first word-program frame after a write enable carries the full start address. Each later frame carries only the two data bytes, and the address steps by two each time. When reporting is enabled and auto-increment mode is active, the serial output pin turns into a live ready/busy line whenever chip select is low. That path is combinational, so no clock edge is needed. While both flags are set, the block accepts only the word-program and write-disable opcodes.

Top module: `autoinc_prog_ctrl`

## Requirements
- R1: After reset the write-enable latch, auto-increment flag and reporting enable are all clear, the program timer is idle, `prog_start` is low and `so_oe` is low.
- R2: A frame holding exactly one byte executes when chip select rises. Byte 06h sets the write-enable latch. Byte 04h clears both the latch and the auto-increment flag. The auto-increment flag is never set while the latch is clear.
- R3: A one-byte frame 70h sets the reporting enable, and a one-byte frame 80h clears it.
- R4: A first word-program frame is exactly six bytes long: ADh, then three address bytes (most significant first), then the low data byte, then the high data byte. It is accepted only when the auto-increment flag is clear. On acceptance it sets the auto-increment flag and raises `prog_start` for one cycle. At that point `prog_addr` holds the address with bit 0 forced to 0, and `prog_data` holds {high byte, low byte}.
- R5: While the auto-increment flag is set, a word-program frame is exactly three bytes long: ADh, low data byte, high data byte. It programs at the previous word address plus 2, wrapping modulo 2^24.
- R6: A word-program frame is ignored, with no `prog_start`, when the write-enable latch is clear, when the program timer is busy, or when its byte count is wrong for the current mode.
- R7: `prog_busy` is high for exactly PROG_CYCLES clock cycles, starting in the cycle in which `prog_start` is high.
- R8: While chip select is low and both the auto-increment flag and the reporting enable are set, `so_oe` is 1 and `so_val` is 0 when busy and 1 when ready. This follows chip select combinationally, with no clock edge in between.
- R9: `so_oe` is 0 whenever chip select is high, and also whenever either the auto-increment flag or the reporting enable is clear.
- R10: While the auto-increment flag and the reporting enable are both set, every opcode other than ADh and 04h has no effect. In particular, 80h leaves the reporting enable set.
- R11: The mode is left by issuing 04h, which clears the latch and the flag and returns `so_oe` to 0, followed by 80h, which is then accepted and clears the reporting enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select level from the front end, active low |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| so_oe | output | 1 | Drive enable for the serial output pin (0 = high impedance) |
| so_val | output | 1 | Value on the serial output pin when driven (0 busy, 1 ready) |
| wr_latch | output | 1 | Write-enable latch |
| auto_mode | output | 1 | Auto-increment programming flag |
| rdy_report_en | output | 1 | Ready/busy reporting enable |
| prog_busy | output | 1 | Internal program operation in progress |
| prog_start | output | 1 | One-cycle pulse that starts a word program |
| prog_addr | output | 24 | Word address for the program |
| prog_data | output | 16 | Word data, low byte in bits 7:0 |

## Verification
The checker assumes that the front end raises `byte_valid` only while chip select is low, at most once per cycle. It also assumes that every frame ends on a byte boundary and that chip select stays high for at least one clock between frames. The bench task that builds frames drives chip select and bytes on falling edges and always inserts idle cycles between frames, so it stays inside these assumptions. Frames that are too short or too long, and frames that arrive while the timer is running, exercise the rejection paths without breaking these input rules.

// File: rtl/autoinc_pkg.sv
package autoinc_pkg;
   localparam logic [7:0] OP_WR_EN     = 8'h06;
   localparam logic [7:0] OP_WR_DIS    = 8'h04;
   localparam logic [7:0] OP_AUTO_WORD = 8'hAD;
   localparam logic [7:0] OP_RPT_ON    = 8'h70;
   localparam logic [7:0] OP_RPT_OFF   = 8'h80;
   localparam int         DATA_BYTES   = 2;
endpackage

// File: rtl/autoinc_frame_rx.sv
module autoinc_frame_rx #(
   parameter int MAX_BYTES = 6,
   parameter int CNT_W     = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      byte_valid,
   input  logic [7:0]                byte_data,
   output logic                      frame_end,
   output logic [CNT_W-1:0]          byte_cnt,
   output logic [MAX_BYTES-1:0][7:0] frame_buf
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BYTES + 1);

   logic cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         byte_cnt <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n)
            byte_cnt <= '0;
         else if (byte_valid && byte_cnt != CNT_SAT)
            byte_cnt <= byte_cnt + CNT_W'(1);
      end
   end

   assign frame_end = cs_n & ~cs_q;

   for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_slot
      logic [7:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (!cs_n && byte_valid && byte_cnt == CNT_W'(gi))
            slot_q <= byte_data;
      end
      assign frame_buf[gi] = slot_q;
   end
endmodule

// File: rtl/autoinc_prog_timer.sv
module autoinc_prog_timer #(
   parameter int PROG_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   localparam int TW = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= load;
      end
      assign busy = busy_q;
   end else begin : g_count
      logic [TW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (load)
            left_q <= TW'(PROG_CYCLES);
         else if (left_q != '0)
            left_q <= left_q - TW'(1);
      end
      assign busy = (left_q != '0);
   end
endmodule

// File: rtl/autoinc_cmd_ctrl.sv
module autoinc_cmd_ctrl
   import autoinc_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int ADDR_W     = 24,
   parameter int MAX_BYTES  = 6,
   parameter int CNT_W      = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_end,
   input  logic [CNT_W-1:0]          byte_cnt,
   input  logic [MAX_BYTES-1:0][7:0] frame_buf,
   input  logic                      prog_busy,
   output logic                      wr_latch,
   output logic                      auto_mode,
   output logic                      rdy_report_en,
   output logic                      word_go,
   output logic                      prog_start,
   output logic [ADDR_W-1:0]         prog_addr,
   output logic [8*DATA_BYTES-1:0]   prog_data
);
   localparam int FIRST_LEN = 1 + ADDR_BYTES + DATA_BYTES;
   localparam int NEXT_LEN  = 1 + DATA_BYTES;

   logic [7:0]              op;
   logic [ADDR_W-1:0]       raw_addr;
   logic [ADDR_W-1:0]       next_addr;
   logic [ADDR_W-1:0]       word_addr;
   logic [8*DATA_BYTES-1:0] word_data;
   logic                    locked;
   logic                    len_ok;
   logic                    single;

   assign op = frame_buf[0];

   for (genvar gk = 0; gk < ADDR_BYTES; gk++) begin : g_addr
      assign raw_addr[8*(ADDR_BYTES-1-gk) +: 8] = frame_buf[1+gk];
   end

   assign locked  = auto_mode & rdy_report_en;
   assign len_ok  = auto_mode ? (byte_cnt == CNT_W'(NEXT_LEN))
                              : (byte_cnt == CNT_W'(FIRST_LEN));
   assign word_go = frame_end && (op == OP_AUTO_WORD) && wr_latch
                    && !prog_busy && len_ok;
   assign single  = frame_end && (byte_cnt == CNT_W'(1));

   assign word_addr = auto_mode ? next_addr : (raw_addr & ~ADDR_W'(1));
   assign word_data = auto_mode ? {frame_buf[2], frame_buf[1]}
                                : {frame_buf[FIRST_LEN-1], frame_buf[FIRST_LEN-2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_latch      <= 1'b0;
         auto_mode     <= 1'b0;
         rdy_report_en <= 1'b0;
         next_addr     <= '0;
      end else if (word_go) begin
         auto_mode <= 1'b1;
         next_addr <= word_addr + ADDR_W'(2);
      end else if (single) begin
         unique case (op)
            OP_WR_DIS: begin
               wr_latch  <= 1'b0;
               auto_mode <= 1'b0;
            end
            OP_WR_EN:   if (!locked) wr_latch      <= 1'b1;
            OP_RPT_ON:  if (!locked) rdy_report_en <= 1'b1;
            OP_RPT_OFF: if (!locked) rdy_report_en <= 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_start <= 1'b0;
         prog_addr  <= '0;
         prog_data  <= '0;
      end else begin
         prog_start <= word_go;
         if (word_go) begin
            prog_addr <= word_addr;
            prog_data <= word_data;
         end
      end
   end
endmodule

// File: rtl/autoinc_so_mux.sv
module autoinc_so_mux (
   input  logic cs_n,
   input  logic auto_mode,
   input  logic rdy_report_en,
   input  logic prog_busy,
   output logic so_oe,
   output logic so_val
);
   assign so_oe  = ~cs_n & auto_mode & rdy_report_en;
   assign so_val = so_oe & ~prog_busy;
endmodule

// File: rtl/autoinc_prog_ctrl.sv
module autoinc_prog_ctrl #(
   parameter int ADDR_BYTES  = 3,
   parameter int PROG_CYCLES = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    byte_valid,
   input  logic [7:0]              byte_data,
   output logic                    so_oe,
   output logic                    so_val,
   output logic                    wr_latch,
   output logic                    auto_mode,
   output logic                    rdy_report_en,
   output logic                    prog_busy,
   output logic                    prog_start,
   output logic [8*ADDR_BYTES-1:0] prog_addr,
   output logic [15:0]             prog_data
);
   localparam int ADDR_W    = 8 * ADDR_BYTES;
   localparam int MAX_BYTES = 1 + ADDR_BYTES + autoinc_pkg::DATA_BYTES;
   localparam int CNT_W     = $clog2(MAX_BYTES + 2);

   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("ADDR_BYTES must lie in 1..4");
   end
   if (PROG_CYCLES < 1) begin : g_bad_time
      $error("PROG_CYCLES must be at least 1");
   end

   logic                      frame_end;
   logic [CNT_W-1:0]          byte_cnt;
   logic [MAX_BYTES-1:0][7:0] frame_buf;
   logic                      word_go;

   autoinc_frame_rx #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .frame_end(frame_end), .byte_cnt(byte_cnt), .frame_buf(frame_buf)
   );

   autoinc_cmd_ctrl #(
      .ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W),
      .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
      .byte_cnt(byte_cnt), .frame_buf(frame_buf), .prog_busy(prog_busy),
      .wr_latch(wr_latch), .auto_mode(auto_mode),
      .rdy_report_en(rdy_report_en), .word_go(word_go),
      .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data)
   );

   autoinc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(word_go), .busy(prog_busy)
   );

   autoinc_so_mux u_so (
      .cs_n(cs_n), .auto_mode(auto_mode), .rdy_report_en(rdy_report_en),
      .prog_busy(prog_busy), .so_oe(so_oe), .so_val(so_val)
   );
endmodule

// File: rtl/autoinc_prog_ctrl_chk.sv
module autoinc_prog_ctrl_chk #(
   parameter int ADDR_W      = 24,
   parameter int PROG_CYCLES = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              so_oe,
   input logic              so_val,
   input logic              wr_latch,
   input logic              auto_mode,
   input logic              rdy_report_en,
   input logic              prog_busy,
   input logic              prog_start,
   input logic [ADDR_W-1:0] prog_addr
);
   localparam int TW = $clog2(PROG_CYCLES + 1);

   logic [TW-1:0]     span_left;
   logic [ADDR_W-1:0] last_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span_left <= '0;
         last_addr <= '0;
      end else begin
         if (prog_start) begin
            span_left <= TW'(PROG_CYCLES - 1);
            last_addr <= prog_addr;
         end else if (span_left != '0) begin
            span_left <= span_left - TW'(1);
         end
      end
   end

   AST_SO_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !so_oe); // R9
   AST_SO_HIZ_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode || !rdy_report_en) |-> !so_oe); // R9
   AST_SO_READY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> (so_val == !prog_busy)); // R8
   AST_SO_LIVE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && auto_mode && rdy_report_en) |-> so_oe); // R8
   AST_MODE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode |-> wr_latch); // R2
   AST_START_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (wr_latch && auto_mode)); // R6
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !$past(prog_busy)); // R6
   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy == (prog_start || span_left != '0)); // R7
   AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !prog_addr[0]); // R4
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start && $past(auto_mode)) |-> (prog_addr == last_addr + ADDR_W'(2))); // R5
   AST_LOCK_KEEPS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && rdy_report_en) |=> rdy_report_en); // R10
endmodule

bind autoinc_prog_ctrl autoinc_prog_ctrl_chk #(
   .ADDR_W(8 * ADDR_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .so_val(so_val),
   .wr_latch(wr_latch), .auto_mode(auto_mode), .rdy_report_en(rdy_report_en),
   .prog_busy(prog_busy), .prog_start(prog_start), .prog_addr(prog_addr)
);

// File: tb/autoinc_prog_ctrl_tb.sv
module autoinc_prog_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PROG_T     = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        so_oe, so_val, wr_latch, auto_mode, rdy_report_en;
   logic        prog_busy, prog_start;
   logic [23:0] prog_addr;
   logic [15:0] prog_data;

   int n_checks = 0;
   int n_fail   = 0;
   int n_starts = 0;
   int busy_run = 0;
   logic [23:0] seen_addr = '0;
   logic [15:0] seen_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   autoinc_prog_ctrl #(.ADDR_BYTES(3), .PROG_CYCLES(PROG_T)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
      .byte_data(byte_data), .so_oe(so_oe), .so_val(so_val),
      .wr_latch(wr_latch), .auto_mode(auto_mode), .rdy_report_en(rdy_report_en),
      .prog_busy(prog_busy), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_data(prog_data)
   );

   always @(negedge clk) begin
      if (prog_start) begin
         n_starts  = n_starts + 1;
         seen_addr = prog_addr;
         seen_data = prog_data;
      end
      if (prog_busy) busy_run = prog_start ? 1 : busy_run + 1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3,
                       input logic [7:0] b4, input logic [7:0] b5);
      logic [7:0] bl [6];
      bl[0] = b0; bl[1] = b1; bl[2] = b2; bl[3] = b3; bl[4] = b4; bl[5] = b5;
      @(negedge clk) cs_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_valid = 1'b1;
         byte_data  = bl[i];
      end
      @(negedge clk);
      byte_valid = 1'b0;
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic op1(input logic [7:0] op);
      send(1, op, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
   endtask

   task automatic wait_ready();
      while (prog_busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic peek_so(output logic oe, output logic val);
      @(negedge clk);
      cs_n = 1'b0;
      #1;
      oe = so_oe; val = so_val;
      cs_n = 1'b1;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic oe, val;
      int   starts0;
      logic [23:0] exp_addr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 latch", wr_latch, 0);
      check("R1 mode", auto_mode, 0);
      check("R1 report", rdy_report_en, 0);
      check("R1 busy", prog_busy, 0);
      check("R1 so_oe", so_oe, 0);

      // R6 word program without latch
      send(6, 8'hAD, 8'h00, 8'h10, 8'h00, 8'h11, 8'h22);
      check("R6 no latch start", n_starts, 0);
      check("R6 no latch mode", auto_mode, 0);

      op1(8'h06);
      check("R2 latch set", wr_latch, 1);
      op1(8'h70);
      check("R3 report on", rdy_report_en, 1);

      // R6 first frame with wrong length
      send(5, 8'hAD, 8'h01, 8'h23, 8'h45, 8'hA5, 8'h00);
      check("R6 short first", n_starts, 0);

      // R4 first word
      send(6, 8'hAD, 8'h01, 8'h23, 8'h45, 8'hA5, 8'h5A);
      check("R4 start", n_starts, 1);
      check("R4 addr", seen_addr, 24'h012344);
      check("R4 data", seen_data, 16'h5AA5);
      check("R4 mode", auto_mode, 1);

      // R8 immediate busy on SO
      peek_so(oe, val);
      check("R8 oe busy", oe, 1);
      check("R8 val busy", val, 0);

      // R6 word while busy
      send(3, 8'hAD, 8'h11, 8'h22, 8'h0, 8'h0, 8'h0);
      check("R6 busy ignore", n_starts, 1);

      wait_ready();
      check("R7 busy span", busy_run, PROG_T);
      peek_so(oe, val);
      check("R8 oe ready", oe, 1);
      check("R8 val ready", val, 1);

      // R5 sweep of follow-on words
      exp_addr = 24'h012344;
      for (int k = 0; k < 6; k++) begin
         exp_addr = exp_addr + 24'd2;
         send(3, 8'hAD, 8'(k * 17), 8'(8'hF0 - k), 8'h0, 8'h0, 8'h0);
         check("R5 count", n_starts, 2 + k);
         check("R5 addr", seen_addr, exp_addr);
         check("R5 data", seen_data, {8'(8'hF0 - k), 8'(k * 17)});
         wait_ready();
      end

      // R6 wrong lengths in auto mode
      starts0 = n_starts;
      send(2, 8'hAD, 8'h01, 8'h0, 8'h0, 8'h0, 8'h0);
      send(4, 8'hAD, 8'h01, 8'h02, 8'h03, 8'h0, 8'h0);
      check("R6 bad length", n_starts, starts0);

      // R10 locked mode ignores others
      op1(8'h80);
      check("R10 report kept", rdy_report_en, 1);
      op1(8'h70);
      op1(8'h05);
      check("R10 mode kept", auto_mode, 1);
      exp_addr = exp_addr + 24'd2;
      send(3, 8'hAD, 8'h33, 8'h44, 8'h0, 8'h0, 8'h0);
      check("R10 word accepted", seen_addr, exp_addr);
      wait_ready();

      // R11 exit sequence
      op1(8'h04);
      check("R11 latch clear", wr_latch, 0);
      check("R11 mode clear", auto_mode, 0);
      peek_so(oe, val);
      check("R9 oe after exit", oe, 0);
      op1(8'h80);
      check("R11 report off", rdy_report_en, 0);

      // R9 auto mode without report enable, wrap of R5
      op1(8'h06);
      send(6, 8'hAD, 8'hFF, 8'hFF, 8'hFF, 8'h01, 8'h02);
      check("R4 wrap first addr", seen_addr, 24'hFFFFFE);
      peek_so(oe, val);
      check("R9 no report oe", oe, 0);
      wait_ready();
      send(3, 8'hAD, 8'h03, 8'h04, 8'h0, 8'h0, 8'h0);
      check("R5 wrap addr", seen_addr, 24'h000000);
      wait_ready();
      op1(8'h04);
      check("R2 clear", wr_latch, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule